// File: doc/BRIEF.md
# Packed-Word Sum-of-Squares Pipeline

This block walks a run of words held in a single-port memory and produces one result per word. Each memory word is 96 bits wide and carries three 32-bit two's-complement integers. The block splits the word into its three fields, squares each one, adds the three squares and writes the 64-bit total to a result memory at the same index the word was read from. The three operands arrive in a single read, so a new word can be issued every clock and one result leaves every clock (initiation interval 1), even though only one read is allowed per cycle.

Software-side control is a start pulse with a word count. The read address runs from 0 to count-1. The datapath has three register stages: the read, a square stage and an add stage. The write address travels alongside the data so that it matches. A one-cycle done pulse follows the final write.

The controller has four states. `ST_IDLE` waits for start. Start with a nonzero count moves to `ST_ISSUE`, and start with a zero count moves to `ST_FINISH`. `ST_ISSUE` issues one read per cycle and moves to `ST_DRAIN` after the last address. `ST_DRAIN` waits until the final result is written and then moves to `ST_FINISH`. `ST_FINISH` raises done for one cycle and always returns to `ST_IDLE`.

Top module: `sqsum_engine`

## Requirements
- R1: After reset, rd_en, wr_en and done are all low, and no read or write happens until start is seen.
- R2: A memory word is split as three 32-bit two's-complement fields: field 0 in bits [31:0], field 1 in bits [63:32] and field 2 in bits [95:64].
- R3: wr_data equals the exact unsigned 64-bit sum of the squares of the three signed fields of the word. This includes words whose fields are all -2^31, and no bit is lost.
- R4: A start seen in `ST_IDLE` with len = N > 0 drives rd_en high on N consecutive cycles, starting the cycle after start, with rd_addr stepping 0, 1, …, N-1 (one read per cycle).
- R5: rd_data is taken one cycle after the matching rd_en. Each result appears with wr_en high exactly three cycles after its read, with wr_addr equal to that read's address, and there is exactly one write per word.
- R6: done is high for exactly one cycle, in the cycle after the last write, and no write occurs in or after that cycle until the next start.
- R7: A start with len = 0 issues no read and no write and raises done in the cycle after start.
- R8: start is ignored while the block is not in `ST_IDLE`. A run in progress keeps its original count and addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run; sampled only when idle |
| len | input | ADDR_W+1 | Number of words in the run (0 to 2^ADDR_W) |
| done | output | 1 | One-cycle pulse after the last result is written |
| rd_en | output | 1 | Read request to the operand memory |
| rd_addr | output | ADDR_W | Read address |
| rd_data | input | LANES*LANE_W | Packed word, valid the cycle after rd_en |
| wr_en | output | 1 | Result write strobe |
| wr_addr | output | ADDR_W | Result write address |
| wr_data | output | 2*LANE_W | Sum of squares |

## Verification
If the lane fields are sliced wrongly or sign-extended wrongly, the sum of squares for the affected word is wrong. That shows at wr_data three cycles after the read. Words made of boundary values such as -1, -2^31 and 2^31-1 make these slips large and visible. If the address pipeline or the controller's counter drifts, wr_addr stops matching the read three cycles earlier, or the read count differs from len. If the drain logic is wrong, done arrives earlier or later than one cycle after the final write, and that is caught on the very run where it happens.

// File: rtl/sqsum_pkg.sv
package sqsum_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ISSUE  = 2'd1,
        ST_DRAIN  = 2'd2,
        ST_FINISH = 2'd3
    } ctrl_state_t;

    // Register stages from read request to write strobe.
    localparam int unsigned READ_TO_WRITE = 3;

endpackage

// File: rtl/sqsum_ctrl.sv
module sqsum_ctrl
    import sqsum_pkg::*;
#(
    parameter int unsigned ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W:0]   len,
    input  logic              stage1_busy,
    input  logic              stage2_busy,
    input  logic              wr_fire,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              done
);

    localparam int unsigned CNT_W = ADDR_W + 1;

    ctrl_state_t      state_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] len_q;
    logic             last_issue;
    logic             last_write;

    assign last_issue = ((cnt_q + CNT_W'(1)) == len_q);
    assign last_write = wr_fire && !stage1_busy && !stage2_busy;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            len_q   <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        cnt_q   <= '0;
                        len_q   <= len;
                        state_q <= (len == '0) ? ST_FINISH : ST_ISSUE;
                    end
                end
                ST_ISSUE: begin
                    if (last_issue) begin
                        state_q <= ST_DRAIN;
                    end else begin
                        cnt_q <= cnt_q + CNT_W'(1);
                    end
                end
                ST_DRAIN: begin
                    if (last_write) begin
                        state_q <= ST_FINISH;
                    end
                end
                ST_FINISH: begin
                    state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Outputs
    always_comb begin
        rd_en   = 1'b0;
        done    = 1'b0;
        rd_addr = cnt_q[ADDR_W-1:0];
        unique case (state_q)
            ST_IDLE:   ;
            ST_ISSUE:  rd_en = 1'b1;
            ST_DRAIN:  ;
            ST_FINISH: done = 1'b1;
            default:   ;
        endcase
    end

    // R4: a burst of reads opens at address zero
    p_first_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_en) |-> (rd_addr == '0));

    // R4: consecutive reads step the address by one
    p_addr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && $past(rd_en)) |-> (rd_addr == $past(rd_addr) + ADDR_W'(1)));

    // R7: empty run finishes the cycle after start
    p_len0_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && start && len == '0) |=> (done && !rd_en));

    // R8: start outside idle does not restart the address walk
    p_start_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ISSUE && !last_issue && start) |=> (rd_en && rd_addr != '0));

endmodule

// File: rtl/sqsum_lane.sv
module sqsum_lane #(
    parameter int unsigned LANE_W = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    input  logic [LANE_W-1:0]     operand,
    output logic [2*LANE_W-1:0]   square
);

    localparam int unsigned SQ_W = 2 * LANE_W;

    logic signed [SQ_W-1:0] op_ext;
    logic signed [SQ_W-1:0] prod;
    logic                   valid_q;

    assign op_ext = SQ_W'(signed'(operand));
    assign prod   = op_ext * op_ext;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            square  <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= in_valid;
            if (in_valid) begin
                square <= prod;
            end
        end
    end

    // R3: a square of a LANE_W-bit signed value never exceeds 2^(2*LANE_W-2)
    p_sq_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        valid_q |-> (square <= (SQ_W'(1) << (SQ_W - 2))));

endmodule

// File: rtl/sqsum_adder.sv
module sqsum_adder #(
    parameter int unsigned LANES  = 3,
    parameter int unsigned RES_W  = 64,
    parameter int unsigned ADDR_W = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        in_valid,
    input  logic [ADDR_W-1:0]           in_addr,
    input  logic [LANES-1:0][RES_W-1:0] sq_bus,
    output logic                        wr_en,
    output logic [ADDR_W-1:0]           wr_addr,
    output logic [RES_W-1:0]            wr_data
);

    logic [RES_W-1:0] total;

    always_comb begin
        total = '0;
        for (int k = 0; k < int'(LANES); k++) begin
            total = total + sq_bus[k];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_en   <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
        end else begin
            wr_en <= in_valid;
            if (in_valid) begin
                wr_addr <= in_addr;
                wr_data <= total;
            end
        end
    end

    // R3: the sum never wraps below any of its terms
    generate
        for (genvar g = 0; g < int'(LANES); g++) begin : g_chk
            p_no_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
                wr_en |-> (wr_data >= $past(sq_bus[g])));
        end
    endgenerate

endmodule

// File: rtl/sqsum_engine.sv
module sqsum_engine
    import sqsum_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned LANE_W = 32,
    parameter int unsigned LANES  = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start,
    input  logic [ADDR_W:0]            len,
    output logic                       done,
    output logic                       rd_en,
    output logic [ADDR_W-1:0]          rd_addr,
    input  logic [LANES*LANE_W-1:0]    rd_data,
    output logic                       wr_en,
    output logic [ADDR_W-1:0]          wr_addr,
    output logic [2*LANE_W-1:0]        wr_data
);

    localparam int unsigned RES_W = 2 * LANE_W;

    // Stage 1: data returning from memory
    logic              v1_q;
    logic [ADDR_W-1:0] a1_q;
    // Stage 2: squares registered
    logic              v2_q;
    logic [ADDR_W-1:0] a2_q;

    logic [LANES-1:0][RES_W-1:0] sq_bus;

    sqsum_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .len         (len),
        .stage1_busy (v1_q),
        .stage2_busy (v2_q),
        .wr_fire     (wr_en),
        .rd_en       (rd_en),
        .rd_addr     (rd_addr),
        .done        (done)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            v1_q <= 1'b0;
            a1_q <= '0;
            v2_q <= 1'b0;
            a2_q <= '0;
        end else begin
            v1_q <= rd_en;
            v2_q <= v1_q;
            if (rd_en) a1_q <= rd_addr;
            if (v1_q)  a2_q <= a1_q;
        end
    end

    generate
        for (genvar g = 0; g < int'(LANES); g++) begin : g_lane
            sqsum_lane #(.LANE_W(LANE_W)) u_lane (
                .clk      (clk),
                .rst_n    (rst_n),
                .in_valid (v1_q),
                .operand  (rd_data[g*LANE_W +: LANE_W]),
                .square   (sq_bus[g])
            );
        end
    endgenerate

    sqsum_adder #(
        .LANES  (LANES),
        .RES_W  (RES_W),
        .ADDR_W (ADDR_W)
    ) u_add (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (v2_q),
        .in_addr  (a2_q),
        .sq_bus   (sq_bus),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data)
    );

    // R5: every read is written back three cycles later
    p_wr_latency_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> ##3 wr_en);

    // R5: write address matches the read issued three cycles earlier
    p_wr_addr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_addr == $past(rd_addr, 3)));

    // R6: done lasts one cycle
    p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6: nothing is written while done is high
    p_done_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!wr_en && !rd_en));

endmodule

// File: tb/sqsum_engine_tb.sv
`timescale 1ns/1ps
module sqsum_engine_tb;

    localparam int AW    = 8;
    localparam int W     = 32;
    localparam int NL    = 3;
    localparam int RW    = 2 * W;
    localparam int DEPTH = 1 << AW;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start = 1'b0;
    logic [AW:0]     len = '0;
    logic            done;
    logic            rd_en;
    logic [AW-1:0]   rd_addr;
    logic [NL*W-1:0] rd_data = '0;
    logic            wr_en;
    logic [AW-1:0]   wr_addr;
    logic [RW-1:0]   wr_data;

    sqsum_engine #(.ADDR_W(AW), .LANE_W(W), .LANES(NL)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .len(len), .done(done),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
    );

    always #2.5 clk = ~clk;

    logic [NL*W-1:0] mem   [DEPTH];
    logic [RW-1:0]   res   [DEPTH];
    int              rdcyc [DEPTH];
    int              wrcyc [DEPTH];
    int cyc = 0;
    int n_rd, n_wr, n_done, done_cyc, last_wr_cyc;
    bit order_bad, wr_after_done;
    int tests = 0;
    int fails = 0;
    bit finished = 0;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (rd_en) rd_data <= mem[rd_addr];
    end

    always @(negedge clk) begin
        if (rst_n) begin
            if (rd_en) begin
                if (rd_addr != AW'(n_rd)) order_bad = 1;
                rdcyc[rd_addr] = cyc;
                n_rd++;
            end
            if (wr_en) begin
                if (n_done != 0) wr_after_done = 1;
                res[wr_addr]   = wr_data;
                wrcyc[wr_addr] = cyc;
                last_wr_cyc    = cyc;
                n_wr++;
            end
            if (done) begin
                done_cyc = cyc;
                n_done++;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input longint unsigned act,
                       input longint unsigned exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] corner(input int d);
        case (d)
            0: return 32'h0000_0000;
            1: return 32'h0000_0001;
            2: return 32'hFFFF_FFFF;
            3: return 32'h8000_0000;
            default: return 32'h7FFF_FFFF;
        endcase
    endfunction

    function automatic logic [RW-1:0] expect_word(input logic [NL*W-1:0] w);
        logic [RW-1:0] s = '0;
        for (int k = 0; k < NL; k++) begin
            logic signed [RW-1:0] a;
            a = RW'($signed(w[k*W +: W]));
            s = s + RW'(a * a);
        end
        return s;
    endfunction

    task automatic fill(input int mode, input int n);
        logic [31:0] x = 32'h1234_5678 ^ 32'(n);
        for (int i = 0; i < DEPTH; i++) begin
            logic [NL*W-1:0] w = '0;
            case (mode)
                0: for (int k = 0; k < NL; k++) begin
                       int d = (i / (k == 0 ? 1 : (k == 1 ? 5 : 25))) % 5;
                       w[k*W +: W] = corner(d);
                   end
                1: for (int k = 0; k < NL; k++) begin
                       x = x ^ (x << 13); x = x ^ (x >> 17); x = x ^ (x << 5);
                       w[k*W +: W] = x;
                   end
                default: w[(i % NL)*W +: W] = 32'(i + 2) | ((i % 2 == 1) ? 32'h8000_0000 : 32'h0);
            endcase
            mem[i] = w;
        end
    endtask

    task automatic run(input int n, input int mode, input bit interrupt);
        int sc, guard;
        fill(mode, n);
        n_rd = 0; n_wr = 0; n_done = 0; done_cyc = -1; last_wr_cyc = -1;
        order_bad = 0; wr_after_done = 0;
        @(negedge clk);
        start = 1'b1; len = (AW+1)'(n); sc = cyc;
        @(negedge clk);
        start = 1'b0;
        if (interrupt) begin
            @(negedge clk); @(negedge clk);
            start = 1'b1; len = (AW+1)'(3);
            @(negedge clk);
            start = 1'b0;
        end
        guard = 0;
        while (n_done == 0 && guard < 2000) begin
            @(negedge clk); guard++;
        end
        repeat (4) @(negedge clk);
        chk(guard < 2000, "R6 done reached", guard, 0);
        chk(n_rd == n, "R4/R8 read count", n_rd, n);
        chk(!order_bad, "R4 ascending addresses", order_bad, 0);
        chk(n_wr == n, "R5 write count", n_wr, n);
        chk(n_done == 1, "R6 single done", n_done, 1);
        chk(!wr_after_done, "R6 no write after done", wr_after_done, 0);
        if (n == 0)
            chk(done_cyc == sc + 1, "R7 empty run done timing", done_cyc, sc + 1);
        else
            chk(done_cyc == last_wr_cyc + 1, "R6 done after last write", done_cyc, last_wr_cyc + 1);
        for (int i = 0; i < n; i++) begin
            logic [RW-1:0] e = expect_word(mem[i]);
            chk(res[i] == e, (mode == 2) ? "R2 field slicing" : "R3 sum of squares", res[i], e);
            chk(rdcyc[i] == sc + 1 + i, "R4 one read per cycle", rdcyc[i], sc + 1 + i);
            chk(wrcyc[i] == rdcyc[i] + 3, "R5 read-to-write latency", wrcyc[i], rdcyc[i] + 3);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) begin
            res[i] = '0; rdcyc[i] = -1; wrcyc[i] = -1;
        end
        repeat (3) @(negedge clk);
        chk(!rd_en && !wr_en && !done, "R1 outputs in reset", {rd_en, wr_en, done}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(!rd_en && !wr_en && !done, "R1 idle after reset", {rd_en, wr_en, done}, 0);

        run(125, 0, 0);        // R3 all corner combinations
        run(DEPTH, 1, 0);      // R3/R4 full address range
        run(1, 2, 0);          // R2
        run(2, 2, 0);          // R2
        run(3, 2, 0);          // R2
        run(0, 1, 0);          // R7
        run(20, 1, 1);         // R8 start while busy
        run(7, 1, 0);          // back-to-back run
        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule